// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins and turns them into clean, synchronous interrupt requests. Every pin is retimed through a two-stage synchroniser. A per-pin sense mode selects falling edge, rising edge, low level, high level or both edges. A detected event sets a pending bit, which stays set until software clears it through the register interface.

A pending pin raises its request line only when two gates are open: its mask bit is clear and its 4-bit priority field is non-zero. The controller drives one request per pin and a shared request that combines all of them. Software programs the block over a simple synchronous bus with separate read and write strobes. The bus exposes five registers:

- sense (address 0)
- priority (address 1)
- pending source (address 2)
- mask-set (address 3)
- mask-clear (address 4)

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, the sense, priority and pending registers all read 0 and every request output is low. All pins are masked and all sense fields select falling edge.
- R2: The sense and priority registers are packed most-significant-first. Pin n owns the field whose least significant bit is 32-(n+1)*W, where W is the field width (4 for priority; 4 by default for sense). Pin 0 therefore sits in bits 31:28.
- R3: Sense code 0 detects a falling edge and code 1 detects a rising edge. The pending bit is set within three clock edges of the pin change and stays set after the pin is stable.
- R4: Sense code 4 detects both rising and falling edges. A pin that does not change produces no event.
- R5: Sense codes 2 (low level) and 3 (high level) set the pending bit on every clock while the synchronised pin is at the active level. A clearing write therefore only takes effect once the pin is inactive.
- R6: Sense codes 5 to 15 never set the pending bit.
- R7: In the pending-source register, pin n is bit FLAG_W-1-n (bit 7-n by default). Writing 0 to a bit clears it, writing 1 leaves it unchanged, and writing all zeros clears every pending bit.
- R8: Writing 1 to bit FLAG_W-1-n of mask-set (address 3) masks pin n. Writing 1 to the same bit of mask-clear (address 4) unmasks it. Zero bits in both registers have no effect, and both registers read as 0.
- R9: A priority field of 0 blocks that pin's request output. Any non-zero value, including 0xF, lets it through.
- R10: The shared request equals the OR of all per-pin request outputs, and a pin's request is high only while its pending bit is set.
- R11: Read data is registered. It shows the addressed register on the cycle after the read strobe and holds that value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register select (0 sense, 1 priority, 2 source, 3 mask-set, 4 mask-clear) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| irq_out | output | NUM_PINS | Per-pin interrupt requests |
| irq_any | output | 1 | OR of all per-pin requests |

## Verification
A corrupted pending latch or a wrong sense decode shows up at the pending-source readback and on `irq_out` within three clocks of the pin change. That delay comes from two synchroniser stages plus the pending register. A stuck mask or priority gate shows on the request lines in the cycle after the bus write, because those outputs are combinational from registered state. A misplaced field or bit shows up as the wrong pin reacting, so stimulus uses a middle pin (pin 2) and the outermost pin (pin 0) to expose reversed or shifted packing.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef enum logic [2:0] {
    REG_SENSE = 3'd0,
    REG_PRIO  = 3'd1,
    REG_SRC   = 3'd2,
    REG_MSET  = 3'd3,
    REG_MCLR  = 3'd4
  } reg_sel_e;

  localparam logic [3:0] SNS_FALL = 4'd0;
  localparam logic [3:0] SNS_RISE = 4'd1;
  localparam logic [3:0] SNS_LOW  = 4'd2;
  localparam logic [3:0] SNS_HIGH = 4'd3;
  localparam logic [3:0] SNS_BOTH = 4'd4;

  localparam int PRIO_W = 4;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int NUM_PINS = 8,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] lvl,
  output logic [NUM_PINS-1:0] lvl_prev
);
  logic [STAGES-1:0][NUM_PINS-1:0] chain_q, chain_d;
  logic [NUM_PINS-1:0]             prev_q;

  always_comb begin
    chain_d[0] = pin_raw;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl      = chain_q[STAGES-1];
  assign lvl_prev = prev_q;
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic [SENSE_W-1:0] mode,
  input  logic               lvl,
  input  logic               lvl_prev,
  output logic               hit
);
  logic [3:0] mode4;

  always_comb begin
    mode4 = '0;
    mode4[SENSE_W-1:0] = mode;
    case (mode4)
      SNS_FALL: hit = lvl_prev & ~lvl;
      SNS_RISE: hit = ~lvl_prev & lvl;
      SNS_LOW:  hit = ~lvl;
      SNS_HIGH: hit = lvl;
      SNS_BOTH: hit = lvl_prev ^ lvl;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int FLAG_W   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] irq_out,
  output logic                irq_any
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // pin retiming and per-pin detection
  logic [NUM_PINS-1:0] lvl, lvl_prev, hit;

  extirq_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin_raw  (pin_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  logic [NUM_PINS-1:0][SENSE_W-1:0] sense_q, sense_d;
  logic [NUM_PINS-1:0][PRIO_W-1:0]  prio_q,  prio_d;
  logic [NUM_PINS-1:0]              pend_q,  pend_d;
  logic [NUM_PINS-1:0]              mask_q,  mask_d;
  logic [DATA_W-1:0]                rdata_q, rdata_d, rd_val;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    extirq_detect #(.SENSE_W(SENSE_W)) u_det (
      .mode     (sense_q[n]),
      .lvl      (lvl[n]),
      .lvl_prev (lvl_prev[n]),
      .hit      (hit[n])
    );
    assign irq_out[n] = pend_q[n] & ~mask_q[n] & (prio_q[n] != '0);
  end

  // register decode
  logic wr_sense, wr_prio, wr_src, wr_mset, wr_mclr;
  assign wr_sense = bus_wr && (bus_addr == REG_SENSE);
  assign wr_prio  = bus_wr && (bus_addr == REG_PRIO);
  assign wr_src   = bus_wr && (bus_addr == REG_SRC);
  assign wr_mset  = bus_wr && (bus_addr == REG_MSET);
  assign wr_mclr  = bus_wr && (bus_addr == REG_MCLR);

  // next state
  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) begin
      sense_d[n] = wr_sense ? bus_wdata[DATA_W-(n+1)*SENSE_W +: SENSE_W] : sense_q[n];
      prio_d[n]  = wr_prio  ? bus_wdata[DATA_W-(n+1)*PRIO_W +: PRIO_W]   : prio_q[n];
      // a new event wins over a clearing write in the same cycle
      pend_d[n]  = hit[n] | (pend_q[n] & ~(wr_src & ~bus_wdata[FLAG_W-1-n]));
      if (wr_mset && bus_wdata[FLAG_W-1-n])      mask_d[n] = 1'b1;
      else if (wr_mclr && bus_wdata[FLAG_W-1-n]) mask_d[n] = 1'b0;
      else                                       mask_d[n] = mask_q[n];
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      case (bus_addr)
        REG_SENSE: rd_val[DATA_W-(n+1)*SENSE_W +: SENSE_W] = sense_q[n];
        REG_PRIO:  rd_val[DATA_W-(n+1)*PRIO_W +: PRIO_W]   = prio_q[n];
        REG_SRC:   rd_val[FLAG_W-1-n]                      = pend_q[n];
        default:   ;
      endcase
    end
    rdata_d = bus_rd ? rd_val : rdata_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sense_q <= '0;
      prio_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      rdata_q <= '0;
    end else begin
      if (wr_sense) sense_q <= sense_d;
      if (wr_prio)  prio_q  <= prio_d;
      pend_q <= pend_d;
      if (wr_mset || wr_mclr) mask_q <= mask_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_any   = |irq_out;
endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk #(
  parameter int NUM_PINS = 8,
  parameter int FLAG_W   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] irq_out,
  input logic                irq_any
);
  // R10: shared request is the OR of the per-pin requests
  a_r10_any_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (|irq_out));

  // R10: no request without a pending event
  a_r10_out_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~pend) == '0);

  // R8: a masked pin never requests
  a_r8_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & mask) == '0);

  // R8: writing ones for every pin to mask-set masks them all
  a_r8_set_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && (&bus_wdata[FLAG_W-1 -: NUM_PINS])) |=> (&mask));

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind extirq_ctrl extirq_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .FLAG_W(FLAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pend      (pend_q),
  .mask      (mask_q),
  .irq_out   (irq_out),
  .irq_any   (irq_any)
);

// File: tb/sim_extirq_ctrl.sv
module sim_extirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  irq_out;
  logic        irq_any;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  extirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq_out(irq_out), .irq_any(irq_any)
  );

  // {sense code, level before, level after, expected pending} for pin 2
  localparam logic [6:0] VEC [0:14] = '{
    {4'd0, 1'b1, 1'b0, 1'b1},   // R3 falling detected
    {4'd0, 1'b0, 1'b1, 1'b0},   // R3 rising ignored in falling mode
    {4'd1, 1'b0, 1'b1, 1'b1},   // R3 rising detected
    {4'd1, 1'b1, 1'b0, 1'b0},   // R3 falling ignored in rising mode
    {4'd2, 1'b1, 1'b0, 1'b1},   // R5 low level
    {4'd2, 1'b0, 1'b1, 1'b1},   // R5 clear while low is ineffective
    {4'd3, 1'b0, 1'b1, 1'b1},   // R5 high level
    {4'd3, 1'b0, 1'b0, 1'b0},   // R5 inactive level
    {4'd4, 1'b0, 1'b1, 1'b1},   // R4 rising in both mode
    {4'd4, 1'b1, 1'b0, 1'b1},   // R4 falling in both mode
    {4'd4, 1'b1, 1'b1, 1'b0},   // R4 no change
    {4'd7, 1'b0, 1'b1, 1'b0},   // R6 unused code
    {4'd15, 1'b1, 1'b0, 1'b0},  // R6 unused code
    {4'd5, 1'b0, 1'b1, 1'b0},   // R6 unused code
    {4'd3, 1'b1, 1'b1, 1'b1}    // R5 steady high
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 sense", v, 32'h0);
    rd(3'd1, v); chk("R1 prio", v, 32'h0);
    rd(3'd2, v); chk("R1 source", v, 32'h0);
    chk("R1 irq_out", {24'h0, irq_out}, 32'h0);
    chk("R1 irq_any", {31'h0, irq_any}, 32'h0);

    // R2 field readback
    wr(3'd0, 32'h0123_4567);
    rd(3'd0, v); chk("R2 sense readback", v, 32'h0123_4567);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0000_00FF);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0);

    // table walk on pin 2 (source bit 5, sense field at bit 20)
    for (int i = 0; i < 15; i++) begin
      wr(3'd0, {8'h0, VEC[i][6:3], 20'h0});
      pin_in[2] = VEC[i][2];
      settle();
      wr(3'd2, 32'h0);
      repeat (2) @(negedge clk);
      pin_in[2] = VEC[i][1];
      settle();
      rd(3'd2, v);
      chk($sformatf("R3-6 vec%0d pending", i), {31'h0, v[5]}, {31'h0, VEC[i][0]});
      chk($sformatf("R3-6 vec%0d irq", i), {31'h0, irq_out[2]}, {31'h0, VEC[i][0]});
    end

    // clean up: pin 2 back high, falling everywhere, clear
    wr(3'd0, 32'h0);
    pin_in[2] = 1'b1;
    settle();
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R7 clear all", v, 32'h0);

    // R2/R7: pin 0 is top sense field and source bit 7
    wr(3'd0, 32'h1000_0000);
    pin_in[0] = 1'b0;
    settle();
    wr(3'd2, 32'h0);
    pin_in[0] = 1'b1;
    settle();
    rd(3'd2, v); chk("R2 pin0 source bit", v, 32'h80);
    chk("R2 pin0 irq", {24'h0, irq_out}, 32'h01);
    chk("R10 irq_any one", {31'h0, irq_any}, 32'h1);

    // R3 falling on pin 3 (bit 4)
    pin_in[3] = 1'b0;
    settle();
    rd(3'd2, v); chk("R3 pin3 falling", v, 32'h90);
    wr(3'd2, 32'h80);
    rd(3'd2, v); chk("R7 write one keeps, zero clears", v, 32'h80);

    // R8 masking
    wr(3'd3, 32'h80);
    chk("R8 mask pin0", {24'h0, irq_out}, 32'h0);
    chk("R10 irq_any masked", {31'h0, irq_any}, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0);
    chk("R8 zero writes ignored", {24'h0, irq_out}, 32'h0);
    wr(3'd4, 32'h80);
    chk("R8 unmask pin0", {24'h0, irq_out}, 32'h01);
    rd(3'd3, v); chk("R8 mask-set reads 0", v, 32'h0);
    rd(3'd4, v); chk("R8 mask-clear reads 0", v, 32'h0);

    // R9 priority gate
    wr(3'd1, 32'h0FFF_FFFF);
    chk("R9 prio 0 blocks", {24'h0, irq_out}, 32'h0);
    wr(3'd1, 32'h1FFF_FFFF);
    chk("R9 prio nonzero passes", {24'h0, irq_out}, 32'h01);
    chk("R10 irq_any again", {31'h0, irq_any}, 32'h1);

    // R11 registered read holds
    rd(3'd1, v); chk("R11 read prio", v, 32'h1FFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 32'h1FFF_FFFF);
    rd(3'd1, v); chk("R11 new read", v, 32'hFFFF_FFFF);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule